// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a byte-lane parallel NOR flash bus. It takes one request at a time over a valid/ready handshake and turns it into a timed sequence of bus cycles: a single array read, a byte program on each selected lane, a sector erase, or a whole-chip erase. The write-type operations start with the fixed unlock writes the flash needs. Each write-enable pulse is stretched to a number of clock cycles worked out from the clock period. After the last command write the block polls the device with ordinary reads until the top data bit of every selected lane shows the finished value.

The bus is 32 bits wide, made of four byte lanes. All four lanes share one address, one chip enable and one output enable, and each lane has its own write enable. Command bytes go out on every selected lane at once, so four devices can be programmed or erased in step. A polling budget supplied with the request sets an upper bound on how long a busy device is waited for. When the budget runs out, the response is returned with an error flag.

Top module: `flash_cmd_seq`

## Requirements
- R1: During and after reset the block is idle: req_ready=1, resp_valid=0, f_ce_n=1, f_oe_n=1, every f_we_n bit 1 and f_dq_oe=0.
- R2: An operation code of 1 (program) issues exactly four writes, in this order: 0xAA to 0x05555, 0x55 to 0x02AAA, 0xA0 to 0x05555, then req_data to req_addr. Command bytes are copied onto every lane. Only the lanes whose req_lanes bit is set pulse their write enable.
- R3: An operation code of 2 (sector erase) issues six writes, in this order: 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, then 0x30 to req_addr as the sector address.
- R4: An operation code of 3 (chip erase) issues the same first five writes as R3, and the sixth is 0x10 to 0x05555.
- R5: Every write-enable low pulse lasts exactly WL_CYC cycles, which is 6 at the defaults. Between two pulses of one operation the enable stays high for at least WH_CYC cycles, which is 4. Address and data do not change while any enable is low.
- R6: After the last write the block polls with reads in which f_oe_n stays low for RD_CYC cycles (14). Consecutive reads are separated by at least OEH_CYC high cycles (2). A program operation is complete when bit 8*i+7 of the sampled data equals bit 8*i+7 of req_data for every selected lane i. An erase operation is complete when that bit is 1 for every selected lane. Lanes that are not selected are never compared.
- R7: On completion resp_valid is high for exactly one cycle. resp_data carries the last sampled bus word and resp_err is 0.
- R8: If poll_limit (at least 1) reads have all failed the completion test, the response carries resp_err=1 and the last sample. Exactly poll_limit reads are issued.
- R9: Operation code 0 (read) performs one read of req_addr with no write pulse and returns the sampled word.
- R10: Output enable and any write enable are never low together, the data bus is never driven during a read, and f_ce_n is low whenever either strobe is low.
- R11: req_ready is low from the cycle after a request is accepted until the response has been given. A req_valid held during that time is not taken and does not disturb the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this cycle |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | 17 | Byte address or sector address |
| req_data | input | 32 | Program data, one byte per lane |
| req_lanes | input | 4 | Lane select for writes and polling |
| poll_limit | input | 32 | Maximum number of polling reads |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_data | output | 32 | Last sampled bus word |
| resp_err | output | 1 | Polling budget exhausted |
| f_addr | output | 17 | Flash address bus |
| f_dq_out | output | 32 | Data driven toward the flash |
| f_dq_oe | output | 1 | Data bus drive enable |
| f_dq_in | input | 32 | Data read from the flash |
| f_ce_n | output | 1 | Chip enable, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_we_n | output | 4 | Per-lane write enable, active low |

## Verification
The checker watches the strobe relationships on every cycle. It measures the width of each write pulse, the high gap before the next pulse and the high gap between polling reads. It also checks that the address and data do not move during a pulse, that read and write strobes never overlap, that resp_valid lasts one cycle and that req_ready falls after acceptance. The bench's flash model shows the rest. It logs every write and compares the unlock and command sequences, answers polls with an inverted top bit for a chosen number of reads, and deliberately mismatches unselected lanes. Only this model can show the lane masking of the completion test, the exact poll count, the timeout boundary and the returned data.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_PROG   = 2'd1,
        OP_SERASE = 2'd2,
        OP_CERASE = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WLOW,
        ST_WHIGH,
        ST_RLOW,
        ST_RGAP,
        ST_RESP
    } fst_e;

    // one bus write of an unlock/command sequence
    typedef struct packed {
        logic        use_uaddr;   // drive the request address
        logic [14:0] fixed_addr;  // otherwise this unlock address
        logic        use_udata;   // drive the request data
        logic [7:0]  cmd;         // otherwise this byte on all lanes
    } cmd_step_t;

    localparam logic [14:0] UNLOCK_HI = 15'h5555;
    localparam logic [14:0] UNLOCK_LO = 15'h2AAA;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] last_idx(input fop_e op);
        return (op == OP_PROG) ? 3'd3 : 3'd5;
    endfunction

    function automatic cmd_step_t cmd_step(input fop_e op, input logic [2:0] idx);
        cmd_step_t s;
        s = '{use_uaddr: 1'b0, fixed_addr: UNLOCK_HI, use_udata: 1'b0, cmd: 8'hAA};
        case (idx)
            3'd0: s.cmd = 8'hAA;
            3'd1: begin s.fixed_addr = UNLOCK_LO; s.cmd = 8'h55; end
            3'd2: s.cmd = (op == OP_PROG) ? 8'hA0 : 8'h80;
            3'd3: begin
                if (op == OP_PROG) begin
                    s.use_uaddr = 1'b1;
                    s.use_udata = 1'b1;
                end
            end
            3'd4: begin s.fixed_addr = UNLOCK_LO; s.cmd = 8'h55; end
            default: begin
                if (op == OP_CERASE) begin
                    s.cmd = 8'h10;
                end else begin
                    s.use_uaddr = 1'b1;
                    s.cmd       = 8'h30;
                end
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] sample7,
    input  logic [LANES-1:0] expect7,
    input  logic [LANES-1:0] lane_en,
    output logic             match
);
    logic [LANES-1:0] lane_ok;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_ok[i] = !lane_en[i] || (sample7[i] == expect7[i]);
    end

    assign match = &lane_ok;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int LANES          = 4,
    parameter int AW             = 17,
    parameter int PLW            = 32,
    parameter int CLK_PERIOD_NS  = 5,
    parameter int WE_LOW_NS      = 30,
    parameter int WE_HIGH_NS     = 20,
    parameter int ADDR_HOLD_NS   = 45,
    parameter int RD_ACCESS_NS   = 70,
    parameter int OE_HIGH_NS     = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [AW-1:0]        req_addr,
    input  logic [8*LANES-1:0]   req_data,
    input  logic [LANES-1:0]     req_lanes,
    input  logic [PLW-1:0]       poll_limit,
    output logic                 resp_valid,
    output logic [8*LANES-1:0]   resp_data,
    output logic                 resp_err,
    output logic [AW-1:0]        f_addr,
    output logic [8*LANES-1:0]   f_dq_out,
    output logic                 f_dq_oe,
    input  logic [8*LANES-1:0]   f_dq_in,
    output logic                 f_ce_n,
    output logic                 f_oe_n,
    output logic [LANES-1:0]     f_we_n
);
    localparam int DW      = 8 * LANES;
    localparam int WH_CYC  = imax(cdiv(WE_HIGH_NS, CLK_PERIOD_NS), 1);
    localparam int WL_CYC  = imax(imax(cdiv(WE_LOW_NS, CLK_PERIOD_NS),
                                       cdiv(ADDR_HOLD_NS, CLK_PERIOD_NS) - WH_CYC), 1);
    localparam int RD_CYC  = imax(cdiv(RD_ACCESS_NS, CLK_PERIOD_NS), 1);
    localparam int OEH_CYC = imax(cdiv(OE_HIGH_NS, CLK_PERIOD_NS), 1);
    localparam int TW      = $clog2(WL_CYC + WH_CYC + RD_CYC + OEH_CYC + 1);

    fst_e               st_q, st_d;
    fop_e               op_q;
    logic [AW-1:0]      uaddr_q;
    logic [DW-1:0]      udata_q;
    logic [DW-1:0]      sample_q;
    logic [LANES-1:0]   lanes_q;
    logic [PLW-1:0]     limit_q;
    logic [PLW-1:0]     polls_q;
    logic [2:0]         idx_q;
    logic               err_q;

    logic               t_load;
    logic [TW-1:0]      t_val;
    logic               t_done;
    cmd_step_t          step;
    logic               last_step;
    logic               poll_ok;
    logic               budget_out;
    logic [LANES-1:0]   exp7;
    logic [LANES-1:0]   smp7;

    assign step       = cmd_step(op_q, idx_q);
    assign last_step  = (idx_q == last_idx(op_q));
    assign budget_out = ({1'b0, polls_q} + 1'b1) >= {1'b0, limit_q};

    for (genvar i = 0; i < LANES; i++) begin : g_bits
        assign exp7[i] = (op_q == OP_PROG) ? udata_q[8*i+7] : 1'b1;
        assign smp7[i] = sample_q[8*i+7];
    end

    flash_seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    flash_poll_eval #(.LANES(LANES)) u_poll (
        .sample7 (smp7),
        .expect7 (exp7),
        .lane_en (lanes_q),
        .match   (poll_ok)
    );

    always_comb begin
        st_d   = st_q;
        t_load = 1'b0;
        t_val  = '0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    t_load = 1'b1;
                    if (fop_e'(req_op) == OP_READ) begin
                        st_d  = ST_RLOW;
                        t_val = TW'(RD_CYC - 1);
                    end else begin
                        st_d  = ST_WSETUP;
                    end
                end
            end
            ST_WSETUP: begin
                if (t_done) begin
                    st_d   = ST_WLOW;
                    t_load = 1'b1;
                    t_val  = TW'(WL_CYC - 1);
                end
            end
            ST_WLOW: begin
                if (t_done) begin
                    st_d   = ST_WHIGH;
                    t_load = 1'b1;
                    t_val  = TW'(WH_CYC - 1);
                end
            end
            ST_WHIGH: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (last_step) begin
                        st_d  = ST_RLOW;
                        t_val = TW'(RD_CYC - 1);
                    end else begin
                        st_d  = ST_WSETUP;
                    end
                end
            end
            ST_RLOW: begin
                if (t_done) begin
                    st_d   = ST_RGAP;
                    t_load = 1'b1;
                    t_val  = TW'(OEH_CYC - 1);
                end
            end
            ST_RGAP: begin
                if (t_done) begin
                    if (op_q == OP_READ || poll_ok || budget_out) begin
                        st_d = ST_RESP;
                    end else begin
                        st_d   = ST_RLOW;
                        t_load = 1'b1;
                        t_val  = TW'(RD_CYC - 1);
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            op_q     <= OP_READ;
            uaddr_q  <= '0;
            udata_q  <= '0;
            sample_q <= '0;
            lanes_q  <= '0;
            limit_q  <= '0;
            polls_q  <= '0;
            idx_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            st_q <= st_d;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= fop_e'(req_op);
                        uaddr_q <= req_addr;
                        udata_q <= req_data;
                        lanes_q <= req_lanes;
                        limit_q <= poll_limit;
                        polls_q <= '0;
                        idx_q   <= '0;
                        err_q   <= 1'b0;
                    end
                end
                ST_WHIGH: begin
                    if (t_done && !last_step) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_RLOW: begin
                    if (t_done) begin
                        sample_q <= f_dq_in;
                    end
                end
                ST_RGAP: begin
                    if (t_done && op_q != OP_READ && !poll_ok) begin
                        polls_q <= polls_q + 1'b1;
                        if (budget_out) begin
                            err_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready  = (st_q == ST_IDLE);
    assign resp_valid = (st_q == ST_RESP);
    assign resp_data  = sample_q;
    assign resp_err   = err_q;

    assign f_ce_n  = (st_q == ST_IDLE) || (st_q == ST_RESP);
    assign f_oe_n  = (st_q != ST_RLOW);
    assign f_dq_oe = (st_q == ST_WSETUP) || (st_q == ST_WLOW) || (st_q == ST_WHIGH);

    for (genvar i = 0; i < LANES; i++) begin : g_we
        assign f_we_n[i] = !((st_q == ST_WLOW) && lanes_q[i]);
    end

    assign f_addr   = (f_dq_oe && !step.use_uaddr) ? AW'(step.fixed_addr) : uaddr_q;
    assign f_dq_out = step.use_udata ? udata_q : {LANES{step.cmd}};

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int LANES   = 4,
    parameter int AW      = 17,
    parameter int WL_CYC  = 6,
    parameter int WH_CYC  = 4,
    parameter int OEH_CYC = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                resp_valid,
    input logic [AW-1:0]       f_addr,
    input logic [8*LANES-1:0]  f_dq_out,
    input logic                f_dq_oe,
    input logic                f_ce_n,
    input logic                f_oe_n,
    input logic [LANES-1:0]    f_we_n
);
    logic        any_low;
    logic        prev_low;
    logic        prev_oe_low;
    logic        pulsed;
    logic        read_seen;
    logic [15:0] low_run;
    logic [15:0] high_run;
    logic [15:0] oe_high_run;

    assign any_low = !(&f_we_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_low    <= 1'b0;
            prev_oe_low <= 1'b0;
            pulsed      <= 1'b0;
            read_seen   <= 1'b0;
            low_run     <= '0;
            high_run    <= '0;
            oe_high_run <= '0;
        end else begin
            prev_low    <= any_low;
            prev_oe_low <= !f_oe_n;
            low_run     <= any_low ? low_run + 1'b1 : '0;
            high_run    <= any_low ? '0 : high_run + 1'b1;
            oe_high_run <= f_oe_n ? oe_high_run + 1'b1 : '0;
            if (f_ce_n) begin
                pulsed    <= 1'b0;
                read_seen <= 1'b0;
            end else begin
                if (any_low) pulsed <= 1'b1;
                if (!f_oe_n) read_seen <= 1'b1;
            end
        end
    end

    // R5
    we_low_width_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_low && !any_low) |-> (low_run >= 16'(WL_CYC)));

    // R5
    we_high_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (any_low && !prev_low && pulsed) |-> (high_run >= 16'(WH_CYC)));

    // R5
    bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (any_low && prev_low) |-> ($stable(f_addr) && $stable(f_dq_out)));

    // R6
    oe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!f_oe_n && !prev_oe_low && read_seen) |-> (oe_high_run >= 16'(OEH_CYC)));

    // R10
    no_strobe_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        any_low |-> (f_oe_n && f_dq_oe));

    // R10
    ce_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (any_low || !f_oe_n) |-> !f_ce_n);

    // R7
    resp_single_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R11
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
    .LANES   (LANES),
    .AW      (AW),
    .WL_CYC  (WL_CYC),
    .WH_CYC  (WH_CYC),
    .OEH_CYC (OEH_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .f_addr     (f_addr),
    .f_dq_out   (f_dq_out),
    .f_dq_oe    (f_dq_oe),
    .f_ce_n     (f_ce_n),
    .f_oe_n     (f_oe_n),
    .f_we_n     (f_we_n)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

    localparam int WL = 6;
    localparam int WH = 4;
    localparam int RD = 14;
    localparam int OEH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [16:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_lanes = '0;
    logic [31:0] poll_limit = '0;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        resp_err;
    logic [16:0] f_addr;
    logic [31:0] f_dq_out;
    logic        f_dq_oe;
    logic [31:0] f_dq_in;
    logic        f_ce_n;
    logic        f_oe_n;
    logic [3:0]  f_we_n;

    always #2.5 clk = ~clk;

    flash_cmd_seq uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_lanes(req_lanes),
        .poll_limit(poll_limit),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_err(resp_err),
        .f_addr(f_addr), .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in),
        .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    int mon_chk = 0;
    int mon_fail = 0;

    // flash model configuration, written only by the stimulus process
    int          req_id = 0;
    int          cfg_busy = 0;
    int          exp_writes = 0;
    logic [31:0] cfg_final = '0;

    // flash model state, written only by the monitor process
    int          seen_id = 0;
    int          log_n = 0;
    logic [16:0] log_a [8];
    logic [31:0] log_d [8];
    logic [3:0]  log_m [8];
    int          busy_left = 0;
    bit          post = 1'b0;
    int          reads = 0;
    int          wl_run = 0;
    int          wh_run = 0;
    int          ol_run = 0;
    int          oh_run = 0;
    bit          pulsed = 1'b0;
    logic [16:0] cap_a;
    logic [31:0] cap_d;
    logic [3:0]  cap_m;

    function automatic logic [31:0] pat(input logic [16:0] a);
        return {~a[7:0], a[15:8], a[7:0] ^ 8'h3C, {7'b0, a[16]} ^ 8'hA5};
    endfunction

    always_comb begin
        if (busy_left > 0)  f_dq_in = cfg_final ^ 32'h80808080;
        else if (post)      f_dq_in = cfg_final;
        else                f_dq_in = pat(f_addr);
    end

    always @(negedge clk) begin
        if (seen_id != req_id) begin
            seen_id   = req_id;
            log_n     = 0;
            busy_left = 0;
            post      = 1'b0;
            reads     = 0;
            pulsed    = 1'b0;
        end
        if (!rst) begin
            if (f_we_n != 4'hF) begin
                if (wl_run == 0 && pulsed) begin
                    mon_chk++;
                    if (wh_run < WH) begin
                        mon_fail++;
                        $display("FAIL R5: write-enable high gap got %0d expected >= %0d", wh_run, WH);
                    end
                end
                wl_run++;
                cap_a = f_addr;
                cap_d = f_dq_out;
                cap_m = ~f_we_n;
            end else begin
                if (wl_run > 0) begin
                    mon_chk++;
                    if (wl_run != WL) begin
                        mon_fail++;
                        $display("FAIL R5: write-enable low width got %0d expected %0d", wl_run, WL);
                    end
                    if (log_n < 8) begin
                        log_a[log_n] = cap_a;
                        log_d[log_n] = cap_d;
                        log_m[log_n] = cap_m;
                    end
                    log_n++;
                    pulsed = 1'b1;
                    wh_run = 0;
                    if (log_n == exp_writes) begin
                        busy_left = cfg_busy;
                        post      = (cfg_busy == 0);
                    end
                end
                wl_run = 0;
                wh_run++;
            end
            if (!f_oe_n) begin
                if (ol_run == 0 && reads > 0) begin
                    mon_chk++;
                    if (oh_run < OEH) begin
                        mon_fail++;
                        $display("FAIL R6: output-enable high gap got %0d expected >= %0d", oh_run, OEH);
                    end
                end
                ol_run++;
            end else begin
                if (ol_run > 0) begin
                    mon_chk++;
                    if (ol_run != RD) begin
                        mon_fail++;
                        $display("FAIL R6: read strobe width got %0d expected %0d", ol_run, RD);
                    end
                    reads++;
                    if (busy_left > 0) begin
                        busy_left--;
                        if (busy_left == 0) post = 1'b1;
                    end
                    oh_run = 0;
                end
                ol_run = 0;
                oh_run++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    // expected {address, data word} of write number i
    function automatic logic [48:0] exp_wr(input int op, input int i,
                                           input logic [16:0] a, input logic [31:0] d);
        case (i)
            0: return {17'h05555, {4{8'hAA}}};
            1: return {17'h02AAA, {4{8'h55}}};
            2: return {17'h05555, {4{(op == 1) ? 8'hA0 : 8'h80}}};
            3: return (op == 1) ? {a, d} : {17'h05555, {4{8'hAA}}};
            4: return {17'h02AAA, {4{8'h55}}};
            default: return (op == 3) ? {17'h05555, {4{8'h10}}} : {a, {4{8'h30}}};
        endcase
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0: return "R9";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic run_req(input int op, input logic [16:0] a, input logic [31:0] d,
                           input logic [3:0] lanes, input int busy, input int limit,
                           input bit hold);
        logic [31:0] fin;
        logic [31:0] exp_data;
        bit          exp_err;
        int          exp_reads;
        int          nw;
        int          wait_n;
        bit          ready_bad;
        for (int l = 0; l < 4; l++) begin
            logic [7:0] b;
            b = (op == 1) ? d[8*l +: 8] : 8'hFF;
            if (!lanes[l]) b = b ^ 8'h80;
            fin[8*l +: 8] = b;
        end
        nw = (op == 0) ? 0 : ((op == 1) ? 4 : 6);
        if (op == 0) begin
            exp_err   = 1'b0;
            exp_reads = 1;
            exp_data  = pat(a);
        end else begin
            exp_err   = (busy >= limit);
            exp_reads = exp_err ? limit : busy + 1;
            exp_data  = exp_err ? (fin ^ 32'h80808080) : fin;
        end
        @(negedge clk);
        cfg_final  = fin;
        cfg_busy   = busy;
        exp_writes = nw;
        req_id++;
        req_op     = 2'(op);
        req_addr   = a;
        req_data   = d;
        req_lanes  = lanes;
        poll_limit = 32'(limit);
        req_valid  = 1'b1;
        @(negedge clk);
        if (hold) begin
            req_op   = 2'd3;
            req_addr = ~a;
        end else begin
            req_valid = 1'b0;
        end
        wait_n    = 0;
        ready_bad = 1'b0;
        while (!resp_valid && wait_n < 20000) begin
            if (req_ready) ready_bad = 1'b1;
            @(negedge clk);
            wait_n++;
        end
        req_valid = 1'b0;
        // watchdog on this request
        chk(resp_valid, "R7 watchdog", 64'(wait_n), 64'd20000);
        if (hold) chk(!ready_bad, "R11 ready while busy", 64'(ready_bad), 64'd0);
        chk(log_n == nw, op_tag(op), 64'(log_n), 64'(nw));
        for (int i = 0; i < nw && i < 8; i++) begin
            logic [48:0] e;
            e = exp_wr(op, i, a, d);
            chk({log_a[i], log_d[i] & {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}}} ==
                {e[48:32], e[31:0] & {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}}},
                op_tag(op), 64'({log_a[i], log_d[i]}), 64'(e));
            chk(log_m[i] == lanes, op_tag(op), 64'(log_m[i]), 64'(lanes));
        end
        chk(reads == exp_reads, "R6 poll count", 64'(reads), 64'(exp_reads));
        chk(resp_data == exp_data, exp_err ? "R8 data" : "R7 data", 64'(resp_data), 64'(exp_data));
        chk(resp_err == exp_err, "R8 error flag", 64'(resp_err), 64'(exp_err));
        @(negedge clk);
        chk(!resp_valid && req_ready, "R7 single pulse", 64'({resp_valid, req_ready}), 64'b01);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid && f_ce_n && f_oe_n && f_we_n == 4'hF && !f_dq_oe, "R1 in reset",
            64'({req_ready, resp_valid, f_ce_n, f_oe_n, f_we_n, f_dq_oe}), 64'b1011_1111_0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !resp_valid && f_ce_n && f_oe_n && f_we_n == 4'hF && !f_dq_oe, "R1 after reset",
            64'({req_ready, resp_valid, f_ce_n, f_oe_n, f_we_n, f_dq_oe}), 64'b1011_1111_0);

        // directed corner cases
        run_req(1, 17'h1_2345, 32'hC3_5A_81_7E, 4'hF, 0, 8, 1'b0);   // R2 done on first poll
        run_req(1, 17'h0_0F0F, 32'h12_F0_0E_99, 4'b0101, 3, 8, 1'b0); // R2 R6 lane mask
        run_req(2, 17'h1_C000, 32'h0, 4'hF, 5, 8, 1'b0);              // R3
        run_req(3, 17'h0_0000, 32'h0, 4'b1000, 2, 8, 1'b0);           // R4
        run_req(0, 17'h1_ABCD, 32'h0, 4'hF, 0, 1, 1'b0);              // R9
        run_req(1, 17'h0_4444, 32'h80_80_80_80, 4'hF, 1000, 5, 1'b0); // R8 timeout
        run_req(2, 17'h0_8000, 32'h0, 4'hF, 4, 5, 1'b0);              // R8 boundary: succeeds on last read
        run_req(2, 17'h0_8000, 32'h0, 4'hF, 5, 5, 1'b0);              // R8 boundary: one too many
        run_req(1, 17'h0_0001, 32'h00_00_00_00, 4'b0010, 0, 1, 1'b0); // R6 limit of one
        run_req(3, 17'h1_FFFF, 32'h0, 4'hF, 2, 8, 1'b1);              // R11 held valid

        // constrained random
        for (int k = 0; k < 30; k++) begin
            int          op;
            logic [3:0]  ln;
            op = int'($urandom_range(0, 3));
            ln = 4'($urandom_range(1, 15));
            run_req(op, 17'($urandom), $urandom, ln,
                    int'($urandom_range(0, 20)), int'($urandom_range(1, 16)),
                    k[2:0] == 3'd5);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
        $finish;
    end

endmodule